// File: doc/BRIEF.md
# Block-cipher register front-end with access-violation monitor

This block is the memory-mapped register front-end and run sequencer for a 64-bit block-cipher accelerator on a plain 32-bit bus. Software loads a mode word, three 64-bit keys, a 64-bit chaining vector and a 64-bit input block. It then starts a run. It can start by writing a start command, or it can let the block start by itself once the input block has been written. When the run completes, the result appears in two read-only output words and a data-ready flag goes up.

The block also watches for bus accesses that are illegal in the current state. These are: reading a register that can only be written, reading the result while a run is in progress, rewriting the mode while a run is in progress, and, in the word-0 start mode, writing the input block while a run is in progress. The first such access sets a sticky error flag and a 2-bit cause code. Both flags can drive one interrupt line through an enable/disable mask.

The cipher datapath itself is replaced by a stub engine with a fixed latency. Its result is the XOR of the input block, the three keys and the chaining vector, inverted bit by bit when the mode selects decryption. With the stub in place, the sequencing, flag and error behaviour can be examined without a real cipher.

Top module: `cph_regfront`

## Requirements
- R1: After reset the status (0x1C), mask (0x18), mode (0x04) and both output words (0x50, 0x54) read zero, and `irq` is low.
- R2: A write to 0x00 with bit 0 set starts a run when idle, in every start mode. Status bit 0 (data ready) rises on the LATENCY+1-th rising edge after the edge that takes the write, and not earlier. The output words then hold, low word at 0x50 and high word at 0x54, din ^ key1 ^ key2 ^ key3 ^ iv. When mode bit 0 is 0 (decrypt) the result is also inverted. Block words sit low at +0 and high at +4, with key1 at 0x20, key2 at 0x28, key3 at 0x30, din at 0x40 and iv at 0x60.
- R3: With mode bits 9:8 = 1, a run starts only after both input words (0x40 and 0x44) have been written, in either order. One word alone starts nothing.
- R4: With mode bits 9:8 = 2, a write to input word 0x40 starts a run. A write to 0x44 alone starts nothing.
- R5: Data ready clears on any of these: a start command, a run started by input writes, a read of 0x50 or 0x54 while idle, or a software reset (write to 0x00 with bit 8 set). A software reset also clears the error flag and cause code and aborts a run. It keeps the mode, keys, data and mask.
- R6: An illegal access sets status bit 8 and writes a cause code into status bits 13:12. The codes are: 0 for an input-word write during a run in mode 2, 1 for an output read during a run, 2 for a mode write during a run, and 3 for a read of a write-only register (0x00, 0x10, 0x14, keys, input, iv). A read of a write-only register returns zero.
- R7: Once bit 8 is set, the first cause code is held and later violations do not change it. Only a software reset clears either one.
- R8: A mode write during a run is ignored. Mode bits read back as bit 0 (encrypt), bits 2:1 (algorithm) and bits 9:8 (start mode), and every other bit reads zero.
- R9: Writing 1 to bit 0 or bit 8 of 0x10 sets that mask bit, and writing 1 to the same bit of 0x14 clears it. The mask reads back at 0x18. `irq` is high exactly when a flag and its mask bit are both set.
- R10: 0x70 holds a 6-bit round count that can be read back. 0xFC reads the VERSION parameter (default 0x105). An undefined offset reads zero and raises no error.
- R11: A read of 0x50 or 0x54 during a run returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address of the 32-bit register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while a read is presented |
| irq | output | 1 | Interrupt: OR of enabled flags |

## Verification
The main function is swept over every start mode, both cipher directions and three sets of data, key and vector values. A wrong XOR term, a missed inversion or a swapped word order each give a different mismatch in the output words. The auto modes are fed input words in both orders, with a long pause after the first word, so that an early start can be told apart from a correct one. Each violation class is provoked on its own after a software reset and then together with an earlier one, which separates correct classification from overwriting of the code. Latency is measured on the interrupt line one cycle on each side of the expected edge.

// File: rtl/cph_pkg.sv
package cph_pkg;

    localparam int DATA_W = 32;
    localparam int BLK_W  = 64;
    localparam int WPB    = BLK_W / DATA_W;
    localparam int NBLK   = 5;

    localparam logic [7:0] OFF_CTRL = 8'h00;
    localparam logic [7:0] OFF_MODE = 8'h04;
    localparam logic [7:0] OFF_IEN  = 8'h10;
    localparam logic [7:0] OFF_IDIS = 8'h14;
    localparam logic [7:0] OFF_MASK = 8'h18;
    localparam logic [7:0] OFF_STAT = 8'h1C;
    localparam logic [7:0] OFF_DOUT = 8'h50;
    localparam logic [7:0] OFF_RNDS = 8'h70;
    localparam logic [7:0] OFF_VER  = 8'hFC;

    // Indices into the 64-bit write-only bank
    localparam int BK_KA  = 0;
    localparam int BK_KB  = 1;
    localparam int BK_KC  = 2;
    localparam int BK_DIN = 3;
    localparam int BK_IV  = 4;

    localparam int CTL_GO   = 0;
    localparam int CTL_SRST = 8;
    localparam int FLG_RDY  = 0;
    localparam int FLG_ERR  = 8;
    localparam int CODE_LSB = 12;

    typedef enum logic [1:0] {
        START_CMD = 2'd0,
        START_ALL = 2'd1,
        START_W0  = 2'd2,
        START_RSV = 2'd3
    } start_mode_e;

    typedef enum logic [1:0] {
        VIOL_DIN_WR  = 2'd0,
        VIOL_DOUT_RD = 2'd1,
        VIOL_MODE_WR = 2'd2,
        VIOL_WO_RD   = 2'd3
    } viol_e;

    typedef struct packed {
        start_mode_e smode;
        logic [1:0]  alg;
        logic        enc;
    } mode_t;

    function automatic logic [7:0] blk_base(input int idx);
        logic [7:0] b;
        case (idx)
            BK_KA:   b = 8'h20;
            BK_KB:   b = 8'h28;
            BK_KC:   b = 8'h30;
            BK_DIN:  b = 8'h40;
            default: b = 8'h60;
        endcase
        return b;
    endfunction

    function automatic mode_t mode_from_word(input logic [DATA_W-1:0] w);
        mode_t m;
        m.enc   = w[0];
        m.alg   = w[2:1];
        m.smode = start_mode_e'(w[9:8]);
        return m;
    endfunction

    function automatic logic [DATA_W-1:0] mode_to_word(input mode_t m);
        logic [DATA_W-1:0] w;
        w      = '0;
        w[0]   = m.enc;
        w[2:1] = m.alg;
        w[9:8] = m.smode;
        return w;
    endfunction

    function automatic logic [DATA_W-1:0] pair_word(input logic lo, input logic hi);
        logic [DATA_W-1:0] w;
        w          = '0;
        w[FLG_RDY] = lo;
        w[FLG_ERR] = hi;
        return w;
    endfunction

    function automatic logic [DATA_W-1:0] status_word(input logic rdy, input logic err,
                                                      input viol_e code);
        logic [DATA_W-1:0] w;
        w = pair_word(rdy, err);
        w[CODE_LSB +: 2] = code;
        return w;
    endfunction

    function automatic logic [BLK_W-1:0] stub_mix(input logic [BLK_W-1:0] din,
                                                  input logic [BLK_W-1:0] k1,
                                                  input logic [BLK_W-1:0] k2,
                                                  input logic [BLK_W-1:0] k3,
                                                  input logic [BLK_W-1:0] iv,
                                                  input logic enc);
        logic [BLK_W-1:0] r;
        r = din ^ k1 ^ k2 ^ k3 ^ iv;
        if (!enc) r = ~r;
        return r;
    endfunction

endpackage

// File: rtl/cph_stub_engine.sv
module cph_stub_engine
    import cph_pkg::*;
#(
    parameter int LATENCY = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             go,
    input  logic [BLK_W-1:0] res_in,
    output logic             busy,
    output logic             done,
    output logic [BLK_W-1:0] res_out
);
    localparam int CW = $clog2(LATENCY + 1);

    logic [CW-1:0]    cnt_q;
    logic [BLK_W-1:0] pend_q;

    assign done = busy && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            busy    <= 1'b0;
            cnt_q   <= '0;
            pend_q  <= '0;
            res_out <= '0;
        end else if (go && !busy) begin
            busy   <= 1'b1;
            cnt_q  <= CW'(LATENCY - 1);
            pend_q <= res_in;
        end else if (done) begin
            busy    <= 1'b0;
            res_out <= pend_q;
        end else if (busy) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

endmodule

// File: rtl/cph_start_seq.sv
module cph_start_seq
    import cph_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           clr,
    input  start_mode_e    smode,
    input  logic           active,
    input  logic           cmd_go,
    input  logic [WPB-1:0] din_wr,
    output logic           go
);
    logic [WPB-1:0] seen_q;
    logic [WPB-1:0] seen_nx;
    logic           trig;

    assign seen_nx = seen_q | din_wr;

    always_comb begin
        trig = 1'b0;
        if (!active) begin
            if (cmd_go) trig = 1'b1;
            else if (smode == START_ALL && (&seen_nx)) trig = 1'b1;
            else if (smode == START_W0 && din_wr[0]) trig = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            go     <= 1'b0;
            seen_q <= '0;
        end else begin
            go     <= trig;
            seen_q <= trig ? '0 : seen_nx;
        end
    end

endmodule

// File: rtl/cph_flags.sv
module cph_flags
    import cph_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       done,
    input  logic       rdy_clr,
    input  logic       viol,
    input  viol_e      viol_code,
    input  logic       ien_wr,
    input  logic       idis_wr,
    input  logic [1:0] sel_bits,
    output logic       ready,
    output logic       err,
    output viol_e      code,
    output logic [1:0] mask,
    output logic       irq
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            ready <= 1'b0;
            err   <= 1'b0;
            code  <= VIOL_DIN_WR;
        end else begin
            if (done)         ready <= 1'b1;
            else if (rdy_clr) ready <= 1'b0;
            if (viol && !err) begin
                err  <= 1'b1;
                code <= viol_code;
            end
        end
    end

    // Mask survives software reset; only the hard reset clears it
    always_ff @(posedge clk) begin
        if (rst) begin
            mask <= '0;
        end else if (ien_wr) begin
            mask <= mask | sel_bits;
        end else if (idis_wr) begin
            mask <= mask & ~sel_bits;
        end
    end

    assign irq = |({err, ready} & mask);

endmodule

// File: rtl/cph_regfront.sv
module cph_regfront
    import cph_pkg::*;
#(
    parameter int          LATENCY = 16,
    parameter int          RND_W   = 6,
    parameter logic [31:0] VERSION = 32'h0000_0105
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq
);
    logic wr, rd;
    assign wr = bus_sel && bus_wr;
    assign rd = bus_sel && !bus_wr;

    // Address decode
    logic ctrl_wr, mode_wr, ien_wr, idis_wr, srst, cmd_go;
    logic [WPB-1:0] din_wr;
    logic [WPB-1:0] dout_hit;
    logic           blk_hit;

    assign ctrl_wr = wr && (bus_addr == OFF_CTRL);
    assign mode_wr = wr && (bus_addr == OFF_MODE);
    assign ien_wr  = wr && (bus_addr == OFF_IEN);
    assign idis_wr = wr && (bus_addr == OFF_IDIS);
    assign srst    = ctrl_wr && bus_wdata[CTL_SRST];
    assign cmd_go  = ctrl_wr && bus_wdata[CTL_GO] && !bus_wdata[CTL_SRST];

    for (genvar g = 0; g < WPB; g++) begin : g_word_dec
        assign din_wr[g]   = wr && (bus_addr == 8'(blk_base(BK_DIN) + 4 * g));
        assign dout_hit[g] = (bus_addr == 8'(OFF_DOUT + 4 * g));
    end

    always_comb begin
        blk_hit = 1'b0;
        for (int b = 0; b < NBLK; b++) begin
            for (int w = 0; w < WPB; w++) begin
                if (bus_addr == 8'(blk_base(b) + 4 * w)) blk_hit = 1'b1;
            end
        end
    end

    // Engine / sequencer / flags interconnect
    logic             go, busy, done, active;
    logic             ready, err;
    viol_e            vcode;
    logic [1:0]       mask;
    logic [BLK_W-1:0] res_q;
    mode_t            mode_q;
    logic [RND_W-1:0] rnds_q;
    logic [BLK_W-1:0] blk_q [NBLK];

    assign active = go || busy;

    // Configuration registers
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            rnds_q <= '0;
        end else begin
            if (mode_wr && !active) mode_q <= mode_from_word(bus_wdata);
            if (wr && bus_addr == OFF_RNDS) rnds_q <= bus_wdata[RND_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int b = 0; b < NBLK; b++) blk_q[b] <= '0;
        end else if (wr) begin
            for (int b = 0; b < NBLK; b++) begin
                for (int w = 0; w < WPB; w++) begin
                    if (bus_addr == 8'(blk_base(b) + 4 * w))
                        blk_q[b][w*DATA_W +: DATA_W] <= bus_wdata;
                end
            end
        end
    end

    // Violation classification
    logic  viol;
    viol_e viol_code;
    logic  wo_rd;
    assign wo_rd = rd && (blk_hit || bus_addr == OFF_CTRL ||
                          bus_addr == OFF_IEN || bus_addr == OFF_IDIS);

    always_comb begin
        viol      = 1'b1;
        viol_code = VIOL_WO_RD;
        if (wo_rd)                                                 viol_code = VIOL_WO_RD;
        else if (rd && (|dout_hit) && active)                      viol_code = VIOL_DOUT_RD;
        else if (mode_wr && active)                                viol_code = VIOL_MODE_WR;
        else if ((|din_wr) && active && mode_q.smode == START_W0)  viol_code = VIOL_DIN_WR;
        else                                                       viol = 1'b0;
    end

    logic rdy_clr;
    assign rdy_clr = (ctrl_wr && bus_wdata[CTL_GO]) || go || (rd && (|dout_hit) && !active);

    cph_start_seq u_seq (
        .clk    (clk),
        .rst    (rst),
        .clr    (srst),
        .smode  (mode_q.smode),
        .active (active),
        .cmd_go (cmd_go),
        .din_wr (din_wr),
        .go     (go)
    );

    cph_stub_engine #(.LATENCY(LATENCY)) u_eng (
        .clk     (clk),
        .rst     (rst),
        .clr     (srst),
        .go      (go),
        .res_in  (stub_mix(blk_q[BK_DIN], blk_q[BK_KA], blk_q[BK_KB], blk_q[BK_KC],
                           blk_q[BK_IV], mode_q.enc)),
        .busy    (busy),
        .done    (done),
        .res_out (res_q)
    );

    cph_flags u_flags (
        .clk       (clk),
        .rst       (rst),
        .clr       (srst),
        .done      (done),
        .rdy_clr   (rdy_clr),
        .viol      (viol),
        .viol_code (viol_code),
        .ien_wr    (ien_wr),
        .idis_wr   (idis_wr),
        .sel_bits  ({bus_wdata[FLG_ERR], bus_wdata[FLG_RDY]}),
        .ready     (ready),
        .err       (err),
        .code      (vcode),
        .mask      (mask),
        .irq       (irq)
    );

    // Read multiplexer
    always_comb begin
        bus_rdata = '0;
        if (rd) begin
            case (bus_addr)
                OFF_MODE: bus_rdata = mode_to_word(mode_q);
                OFF_MASK: bus_rdata = pair_word(mask[0], mask[1]);
                OFF_STAT: bus_rdata = status_word(ready, err, vcode);
                OFF_RNDS: bus_rdata = {{(DATA_W-RND_W){1'b0}}, rnds_q};
                OFF_VER:  bus_rdata = VERSION;
                default: begin
                    for (int w = 0; w < WPB; w++) begin
                        if (dout_hit[w] && !active) bus_rdata = res_q[w*DATA_W +: DATA_W];
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/cph_sva.sv
module cph_sva (
    input logic       clk,
    input logic       rst,
    input logic       srst,
    input logic       go,
    input logic       busy,
    input logic       done,
    input logic       active,
    input logic       ready,
    input logic       err,
    input logic [1:0] vcode,
    input logic       mode_wr,
    input logic [4:0] mode_bits
);
    // R7: error flag is sticky until software reset
    a_r7_err_sticky: assert property (@(posedge clk) disable iff (rst)
        (err && !srst) |=> err);

    // R7: first cause code is held
    a_r7_code_held: assert property (@(posedge clk) disable iff (rst)
        (err && !srst) |=> $stable(vcode));

    // R8: mode write during a run leaves the mode unchanged
    a_r8_mode_frozen: assert property (@(posedge clk) disable iff (rst)
        (active && mode_wr) |=> $stable(mode_bits));

    // R2: an accepted start makes the engine busy next cycle
    a_r2_go_busy: assert property (@(posedge clk) disable iff (rst)
        (go && !srst) |=> busy);

    // R2: completion raises data ready
    a_r2_done_ready: assert property (@(posedge clk) disable iff (rst)
        (done && !srst) |=> ready);

    // R5: data ready is never shown while a run is in progress
    a_r5_idle_ready: assert property (@(posedge clk) disable iff (rst)
        busy |-> !ready);

endmodule

bind cph_regfront cph_sva u_sva (
    .clk       (clk),
    .rst       (rst),
    .srst      (srst),
    .go        (go),
    .busy      (busy),
    .done      (done),
    .active    (active),
    .ready     (ready),
    .err       (err),
    .vcode     (vcode),
    .mode_wr   (mode_wr),
    .mode_bits (mode_q)
);

// File: tb/test_cph_regfront.sv
module test_cph_regfront;
    localparam int LAT = 16;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_sel, bus_wr;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    cph_regfront #(.LATENCY(LAT)) i_cph_regfront (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %08h expected %08h", tag, got, exp);
        end
    endtask

    // Called just after a falling edge; the access lands on the next rising edge
    task automatic wr32(input logic [7:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd32(input logic [7:0] a, output logic [31:0] v);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [63:0] key_of(input int i, input int p);
        return {32'hA5A5_0000 + 32'(i * 17 + p), 32'h0101_0101 * 32'(i + p + 1)};
    endfunction

    function automatic logic [63:0] iv_of(input int p);
        return {32'h0F0F_0F0F * 32'(p + 3), 32'hC3C3_3C3C ^ 32'(p * 255)};
    endfunction

    function automatic logic [63:0] din_of(input int p);
        return {32'h1357_9BDF ^ (32'h0101_0101 * 32'(p)), 32'h2468_ACE0 + 32'(p * 4369)};
    endfunction

    task automatic run_one(input int sm, input int enc, input int p);
        logic [63:0] d, exp;
        logic [31:0] v;
        string tg;
        tg = (sm == 0) ? "R2" : (sm == 1) ? "R3" : "R4";
        d   = din_of(p);
        exp = d ^ iv_of(p);
        wr32(8'h04, 32'((sm << 8) | ((p % 2) << 1) | enc));
        for (int i = 0; i < 3; i++) begin
            wr32(8'(8'h20 + 8 * i), key_of(i, p)[31:0]);
            wr32(8'(8'h24 + 8 * i), key_of(i, p)[63:32]);
            exp = exp ^ key_of(i, p);
        end
        if (enc == 0) exp = ~exp;
        wr32(8'h60, iv_of(p)[31:0]);
        wr32(8'h64, iv_of(p)[63:32]);
        if (sm == 0) begin
            wr32(8'h40, d[31:0]);
            wr32(8'h44, d[63:32]);
            idle(LAT + 2);
            rd32(8'h1C, v); chk({tg, " no start without command"}, v, 32'h0);
            wr32(8'h00, 32'h1);
        end else if (sm == 1 && p % 2 == 1) begin
            wr32(8'h44, d[63:32]);
            idle(LAT + 2);
            rd32(8'h1C, v); chk({tg, " one word does not start"}, v, 32'h0);
            wr32(8'h40, d[31:0]);
        end else begin
            wr32(8'h40 + ((sm == 1) ? 8'h0 : 8'h4), (sm == 1) ? d[31:0] : d[63:32]);
            idle(LAT + 2);
            rd32(8'h1C, v); chk({tg, " partial write does not start"}, v, 32'h0);
            if (sm == 1) wr32(8'h44, d[63:32]);
            else         wr32(8'h40, d[31:0]);
        end
        idle(LAT + 2);
        rd32(8'h1C, v); chk({tg, " ready after run"}, v, 32'h1);
        rd32(8'h50, v); chk({tg, " out lo"}, v, exp[31:0]);
        rd32(8'h54, v); chk({tg, " out hi"}, v, exp[63:32]);
        rd32(8'h1C, v); chk("R5 ready cleared by output read", v, 32'h0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog all requirements: got hang expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] v;
        rst = 1'b1; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd32(8'h1C, v); chk("R1 status", v, 32'h0);
        rd32(8'h18, v); chk("R1 mask", v, 32'h0);
        rd32(8'h04, v); chk("R1 mode", v, 32'h0);
        rd32(8'h50, v); chk("R1 out lo", v, 32'h0);
        rd32(8'h54, v); chk("R1 out hi", v, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);

        // Sweep: start mode x direction x data set
        for (int sm = 0; sm < 3; sm++)
            for (int enc = 0; enc < 2; enc++)
                for (int p = 0; p < 3; p++)
                    run_one(sm, enc, p);

        // R2 latency and R9 interrupt masking
        wr32(8'h04, 32'h0000_0001);
        wr32(8'h10, 32'h1);
        rd32(8'h18, v); chk("R9 mask set bit 0", v, 32'h1);
        wr32(8'h00, 32'h1);
        idle(LAT);
        chk("R2 not ready at LATENCY edges", {31'b0, irq}, 32'h0);
        idle(1);
        chk("R2 ready at LATENCY+1 edges", {31'b0, irq}, 32'h1);
        wr32(8'h14, 32'h1);
        chk("R9 irq off after disable", {31'b0, irq}, 32'h0);
        rd32(8'h1C, v); chk("R9 flag kept when masked", v, 32'h1);
        wr32(8'h10, 32'h100);
        rd32(8'h18, v); chk("R9 mask bit 8 only", v, 32'h100);

        // R5 clear by start command, then by software reset, then by hi-word read
        wr32(8'h00, 32'h1);
        rd32(8'h1C, v); chk("R5 start command clears ready", v, 32'h0);
        idle(LAT + 2);
        rd32(8'h1C, v); chk("R5 ready again", v, 32'h1);
        wr32(8'h00, 32'h100);
        rd32(8'h1C, v); chk("R5 software reset clears ready", v, 32'h0);
        wr32(8'h00, 32'h1);
        idle(LAT + 2);
        rd32(8'h54, v);
        rd32(8'h1C, v); chk("R5 hi-word read clears ready", v, 32'h0);

        // R6 code 0 in start mode 2, then R7 holding against a code 2 access
        wr32(8'h04, 32'h0000_0200);
        wr32(8'h40, 32'h1111_1111);
        wr32(8'h40, 32'h2222_2222);
        rd32(8'h1C, v); chk("R6 code 0 input write during run", v, 32'h0000_0100);
        chk("R9 irq on error flag", {31'b0, irq}, 32'h1);
        idle(LAT + 2);
        rd32(8'h1C, v); chk("R7 error kept after run", v, 32'h0000_0101);
        wr32(8'h00, 32'h1);
        wr32(8'h04, 32'h0000_0003);
        rd32(8'h04, v); chk("R8 mode write during run ignored", v, 32'h0000_0200);
        rd32(8'h1C, v); chk("R7 first code held", v, 32'h0000_0100);
        wr32(8'h00, 32'h100);
        rd32(8'h1C, v); chk("R7 software reset clears error", v, 32'h0);
        rd32(8'h04, v); chk("R5 software reset keeps mode", v, 32'h0000_0200);

        // R6 code 1 and R11
        wr32(8'h00, 32'h1);
        rd32(8'h50, v); chk("R11 output read during run is zero", v, 32'h0);
        rd32(8'h1C, v); chk("R6 code 1 output read during run", v, 32'h0000_1100);
        wr32(8'h00, 32'h100);

        // R6 code 2
        wr32(8'h04, 32'h0000_0000);
        wr32(8'h00, 32'h1);
        wr32(8'h04, 32'h0000_0005);
        rd32(8'h1C, v); chk("R6 code 2 mode write during run", v, 32'h0000_2100);
        rd32(8'h04, v); chk("R8 mode unchanged", v, 32'h0);
        wr32(8'h00, 32'h100);
        wr32(8'h04, 32'hFFFF_FFFF);
        rd32(8'h04, v); chk("R8 mode field readback", v, 32'h0000_0307);

        // R6 code 3
        rd32(8'h24, v); chk("R6 write-only read returns zero", v, 32'h0);
        rd32(8'h1C, v); chk("R6 code 3 write-only read", v, 32'h0000_3100);
        wr32(8'h00, 32'h100);
        rd32(8'h00, v); chk("R6 control read returns zero", v, 32'h0);
        rd32(8'h1C, v); chk("R6 code 3 control read", v, 32'h0000_3100);
        wr32(8'h00, 32'h100);

        // R10 misc map
        wr32(8'h70, 32'hFFFF_FFEA);
        rd32(8'h70, v); chk("R10 round count 6 bits", v, 32'h0000_002A);
        rd32(8'hFC, v); chk("R10 version", v, 32'h0000_0105);
        rd32(8'h08, v); chk("R10 undefined reads zero", v, 32'h0);
        rd32(8'h1C, v); chk("R10 undefined raises no error", v, 32'h0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule